// File: doc/BRIEF.md
# Associative Rename Buffer

This block holds the in-flight instances of architectural registers for an out-of-order core. It is a ring of rename entries with a head pointer and a tail pointer. Each entry records the architectural register it stands for, a flag marking it as the most recent instance of that register, a flag saying its result has arrived, and the result itself. An issue group of `ISSUE_W` instructions is renamed in one cycle. Every destination gets a new entry, even when its register is already renamed, so write-after-write hazards vanish. Every source is looked up associatively and returns either a value or the index of the entry it must wait on.

Execution units write results back into entries by index. Retirement takes the entry at the tail, copies its result into the architectural register file, and frees it. The architectural file is modelled inside the block. A lookup that finds no live, most-recent entry reads the architectural file.

Top module: `rnb_top`

## Requirements
- R1: Granted allocations receive consecutive entry indices starting at the head pointer, in slot order (slot 0 first), with the index wrapping modulo `NUM_REN`. Each destination gets a fresh entry, even when that register already has one.
- R2: When the number of requested allocations exceeds the number of free entries, `stall_o` is 1 and no slot of the group is allocated (the head does not move). Otherwise `stall_o` is 0.
- R3: When an architectural register has several live entries, a lookup returns only the most recently allocated one. This includes two allocations to one register in the same group.
- R4: A lookup whose register maps to a live entry that has no result yet returns `src_rdy_o`=0 and `src_tag_o` equal to that entry's index.
- R5: A lookup whose register maps to a live entry holding a result returns `src_rdy_o`=1 and that result, in preference to the architectural file.
- R6: A lookup whose register has no live mapping returns `src_rdy_o`=1 and the architectural file value.
- R7: Lookup `l` belongs to slot `l / NSRC`. It sees the destinations granted to strictly older slots of the same group: if the youngest such slot writes the looked-up register, the result is `src_rdy_o`=0 with that slot's allocated index. The slot's own destination is not visible to its own sources.
- R8: A writeback to a live entry stores the data and marks it ready. Lookups see this from the next cycle. A writeback to a free entry is ignored, so a later allocation of that entry still reads as not ready.
- R9: With `retire_i`=1, when the tail entry is live and ready, `retire_ok_o`=1, the result is written to the architectural file, the entry is freed and the tail advances. Lookups of that register then return the retired value (unless the register was renamed again). Otherwise `retire_ok_o`=0 and nothing changes.
- R10: After reset the buffer is empty, every architectural register reads 0 and ready, and `stall_o` is 0.
- R11: When allocation and retirement fall in the same cycle, free space is judged before the retirement. A full buffer therefore still stalls while retiring, and the freed entry can be allocated from the next cycle on. When space suffices, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_en_i | input | ISSUE_W | Per-slot destination allocation request |
| dest_i | input | ISSUE_W x AW | Per-slot destination architectural register |
| src_i | input | NLOOK x AW | Source registers, NSRC per slot, slot 0 first |
| alloc_tag_o | output | ISSUE_W x RW | Entry index given to each slot (meaningful when granted) |
| stall_o | output | 1 | Group could not be allocated this cycle |
| src_rdy_o | output | NLOOK | Source value available |
| src_val_o | output | NLOOK x DW | Source value when ready |
| src_tag_o | output | NLOOK x RW | Entry to wait on when not ready |
| wb_en_i | input | 1 | Result writeback strobe |
| wb_tag_i | input | RW | Entry index of the writeback |
| wb_data_i | input | DW | Writeback data |
| retire_i | input | 1 | Request to retire the tail entry |
| retire_ok_o | output | 1 | Tail entry retired this cycle |

## Verification
Retirement and allocation can fall in the same cycle. So can a writeback and a lookup of the same entry. The bench fills the buffer and then requests one allocation together with a retirement. It expects a stall with the retirement taking place, followed by a grant of the freed index one cycle later. It also writes back an entry while looking it up and expects the not-ready answer until the next cycle. Long random sweeps at three retirement densities keep the buffer near empty, half full and full. Each cycle is judged against a map-table model in the bench, which also scores every cycle in which a retirement and a grant coincide.

// File: rtl/rnb_pkg.sv
package rnb_pkg;

  // Which path answered a source lookup.
  typedef enum logic [1:0] {
    LK_ARCH  = 2'd0,
    LK_ENTRY = 2'd1,
    LK_GROUP = 2'd2
  } lk_src_e;

endpackage

// File: rtl/rnb_alloc.sv
module rnb_alloc #(
  parameter  int ISSUE_W = 2,
  parameter  int NUM_REN = 8,
  localparam int RW      = $clog2(NUM_REN),
  localparam int CNTW    = $clog2(NUM_REN + ISSUE_W + 1) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ISSUE_W-1:0]          alloc_en_i,
  input  logic                        retire_i,
  input  logic                        tail_done_i,
  output logic [ISSUE_W-1:0]          grant_o,
  output logic [ISSUE_W-1:0][RW-1:0]  tag_o,
  output logic                        stall_o,
  output logic                        retire_ok_o,
  output logic [RW-1:0]               tail_o
);

  logic [RW-1:0]   head_q, head_n, tail_q, tail_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [CNTW-1:0] n_req, n_grant, free_slots;
  logic            head_en, tail_en, cnt_en;

  always_comb begin
    n_req = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      n_req = n_req + CNTW'(alloc_en_i[k]);
    end
    free_slots = CNTW'(NUM_REN) - cnt_q;
    stall_o    = (n_req > free_slots);
    grant_o    = stall_o ? '0 : alloc_en_i;

    n_grant = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      tag_o[k] = head_q + n_grant[RW-1:0];
      n_grant  = n_grant + CNTW'(grant_o[k]);
    end

    retire_ok_o = retire_i & tail_done_i;

    head_en = |grant_o;
    head_n  = head_q + n_grant[RW-1:0];
    tail_en = retire_ok_o;
    tail_n  = tail_q + RW'(1);
    cnt_en  = head_en | tail_en;
    cnt_n   = cnt_q + n_grant - CNTW'(retire_ok_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (head_en) head_q <= head_n;
      if (tail_en) tail_q <= tail_n;
      if (cnt_en)  cnt_q  <= cnt_n;
    end
  end

  assign tail_o = tail_q;

  // R2: occupancy never exceeds the ring size
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(NUM_REN));

  // R1: pointer distance always equals the occupancy
  a_r1_ring_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q - tail_q) == cnt_q[RW-1:0]);

  // R2: a stalled group leaves the head where it was
  a_r2_stall_freezes_head: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> head_q == $past(head_q));

endmodule

// File: rtl/rnb_entries.sv
module rnb_entries #(
  parameter  int ISSUE_W  = 2,
  parameter  int NUM_REN  = 8,
  parameter  int NUM_ARCH = 8,
  parameter  int DW       = 16,
  localparam int RW       = $clog2(NUM_REN),
  localparam int AW       = $clog2(NUM_ARCH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ISSUE_W-1:0]           grant_i,
  input  logic [ISSUE_W-1:0][AW-1:0]   dest_i,
  input  logic [ISSUE_W-1:0][RW-1:0]   tag_i,
  input  logic                         wb_en_i,
  input  logic [RW-1:0]                wb_tag_i,
  input  logic [DW-1:0]                wb_data_i,
  input  logic                         free_en_i,
  input  logic [RW-1:0]                free_tag_i,
  output logic [NUM_REN-1:0]           occ_o,
  output logic [NUM_REN-1:0]           lat_o,
  output logic [NUM_REN-1:0]           rdy_o,
  output logic [NUM_REN-1:0][AW-1:0]   arch_o,
  output logic [NUM_REN-1:0][DW-1:0]   data_o
);

  logic [NUM_REN-1:0]         occ_q, occ_n, lat_q, lat_n, rdy_q, rdy_n;
  logic [NUM_REN-1:0][AW-1:0] arch_q, arch_n;
  logic [NUM_REN-1:0][DW-1:0] data_q, data_n;
  logic [NUM_REN-1:0]         pay_we;

  always_comb begin
    occ_n  = occ_q;
    lat_n  = lat_q;
    rdy_n  = rdy_q;
    arch_n = arch_q;
    data_n = data_q;
    pay_we = '0;
    for (int i = 0; i < NUM_REN; i++) begin
      // result arrives for a live entry
      if (wb_en_i && (wb_tag_i == RW'(i)) && occ_q[i]) begin
        rdy_n[i]  = 1'b1;
        data_n[i] = wb_data_i;
        pay_we[i] = 1'b1;
      end
      // retirement frees the tail entry
      if (free_en_i && (free_tag_i == RW'(i))) begin
        occ_n[i] = 1'b0;
        lat_n[i] = 1'b0;
        rdy_n[i] = 1'b0;
      end
      // a new instance of the same register demotes this one
      for (int k = 0; k < ISSUE_W; k++) begin
        if (grant_i[k] && occ_q[i] && (dest_i[k] == arch_q[i])) begin
          lat_n[i] = 1'b0;
        end
      end
      // fresh allocation into this entry
      for (int k = 0; k < ISSUE_W; k++) begin
        if (grant_i[k] && (tag_i[k] == RW'(i))) begin
          occ_n[i]  = 1'b1;
          rdy_n[i]  = 1'b0;
          arch_n[i] = dest_i[k];
          pay_we[i] = 1'b1;
          lat_n[i]  = 1'b1;
          for (int m = k + 1; m < ISSUE_W; m++) begin
            if (grant_i[m] && (dest_i[m] == dest_i[k])) lat_n[i] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      lat_q <= '0;
      rdy_q <= '0;
    end else begin
      occ_q <= occ_n;
      lat_q <= lat_n;
      rdy_q <= rdy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arch_q <= '0;
      data_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REN; i++) begin
        if (pay_we[i]) begin
          arch_q[i] <= arch_n[i];
          data_q[i] <= data_n[i];
        end
      end
    end
  end

  assign occ_o  = occ_q;
  assign lat_o  = lat_q;
  assign rdy_o  = rdy_q;
  assign arch_o = arch_q;
  assign data_o = data_q;

  // R3: at most one live most-recent instance per architectural register
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_one_latest
    logic [NUM_REN-1:0] hold_a;
    always_comb begin
      for (int i = 0; i < NUM_REN; i++) begin
        hold_a[i] = occ_q[i] & lat_q[i] & (arch_q[i] == AW'(a));
      end
    end
    a_r3_single_latest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hold_a) <= 1);
  end

  // R8: a writeback into a live entry that is not retiring leaves it ready
  a_r8_wb_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_i && occ_q[wb_tag_i] && !(free_en_i && (free_tag_i == wb_tag_i)))
    |=> rdy_q[$past(wb_tag_i)]);

  // R9: a retired entry is free afterwards
  a_r9_free_clears: assert property (@(posedge clk) disable iff (!rst_n)
    free_en_i |=> !occ_q[$past(free_tag_i)]);

endmodule

// File: rtl/rnb_lookup.sv
module rnb_lookup
  import rnb_pkg::*;
#(
  parameter  int ISSUE_W  = 2,
  parameter  int NSRC     = 2,
  parameter  int NUM_REN  = 8,
  parameter  int NUM_ARCH = 8,
  parameter  int DW       = 16,
  localparam int RW       = $clog2(NUM_REN),
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int NLOOK    = ISSUE_W * NSRC
) (
  input  logic [NUM_REN-1:0]           occ_i,
  input  logic [NUM_REN-1:0]           lat_i,
  input  logic [NUM_REN-1:0]           rdy_i,
  input  logic [NUM_REN-1:0][AW-1:0]   arch_i,
  input  logic [NUM_REN-1:0][DW-1:0]   data_i,
  input  logic [NUM_ARCH-1:0][DW-1:0]  arf_i,
  input  logic [ISSUE_W-1:0]           grant_i,
  input  logic [ISSUE_W-1:0][AW-1:0]   dest_i,
  input  logic [ISSUE_W-1:0][RW-1:0]   tag_i,
  input  logic [NLOOK-1:0][AW-1:0]     src_i,
  output logic [NLOOK-1:0]             rdy_o,
  output logic [NLOOK-1:0][DW-1:0]     val_o,
  output logic [NLOOK-1:0][RW-1:0]     tag_o
);

  lk_src_e [NLOOK-1:0] kind;

  always_comb begin
    for (int l = 0; l < NLOOK; l++) begin
      logic [RW-1:0] hidx;
      logic [RW-1:0] gtag;
      logic          hit;
      hit  = 1'b0;
      hidx = '0;
      gtag = '0;
      // associative search for the most recent live instance
      for (int i = 0; i < NUM_REN; i++) begin
        if (occ_i[i] && lat_i[i] && (arch_i[i] == src_i[l])) begin
          hit  = 1'b1;
          hidx = RW'(i);
        end
      end
      kind[l] = hit ? LK_ENTRY : LK_ARCH;
      // older slots of the same group override, youngest older wins
      for (int k = 0; k < (l / NSRC); k++) begin
        if (grant_i[k] && (dest_i[k] == src_i[l])) begin
          kind[l] = LK_GROUP;
          gtag    = tag_i[k];
        end
      end
      unique case (kind[l])
        LK_ENTRY: begin
          rdy_o[l] = rdy_i[hidx];
          val_o[l] = rdy_i[hidx] ? data_i[hidx] : '0;
          tag_o[l] = hidx;
        end
        LK_GROUP: begin
          rdy_o[l] = 1'b0;
          val_o[l] = '0;
          tag_o[l] = gtag;
        end
        default: begin
          rdy_o[l] = 1'b1;
          val_o[l] = arf_i[src_i[l]];
          tag_o[l] = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/rnb_top.sv
module rnb_top #(
  parameter  int NUM_ARCH = 8,
  parameter  int NUM_REN  = 8,
  parameter  int DW       = 16,
  parameter  int ISSUE_W  = 2,
  parameter  int NSRC     = 2,
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int RW       = $clog2(NUM_REN),
  localparam int NLOOK    = ISSUE_W * NSRC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ISSUE_W-1:0]          alloc_en_i,
  input  logic [ISSUE_W-1:0][AW-1:0]  dest_i,
  input  logic [NLOOK-1:0][AW-1:0]    src_i,
  output logic [ISSUE_W-1:0][RW-1:0]  alloc_tag_o,
  output logic                        stall_o,
  output logic [NLOOK-1:0]            src_rdy_o,
  output logic [NLOOK-1:0][DW-1:0]    src_val_o,
  output logic [NLOOK-1:0][RW-1:0]    src_tag_o,
  input  logic                        wb_en_i,
  input  logic [RW-1:0]               wb_tag_i,
  input  logic [DW-1:0]               wb_data_i,
  input  logic                        retire_i,
  output logic                        retire_ok_o
);

  logic [ISSUE_W-1:0]          grant;
  logic [ISSUE_W-1:0][RW-1:0]  tag;
  logic [RW-1:0]               tail;
  logic                        tail_done;
  logic [NUM_REN-1:0]          occ, lat, rdy;
  logic [NUM_REN-1:0][AW-1:0]  arch;
  logic [NUM_REN-1:0][DW-1:0]  data;
  logic [NUM_ARCH-1:0][DW-1:0] arf_q;
  logic                        arf_we;
  logic [AW-1:0]               arf_idx;
  logic [DW-1:0]               arf_wdata;

  assign tail_done   = occ[tail] & rdy[tail];
  assign alloc_tag_o = tag;

  rnb_alloc #(.ISSUE_W(ISSUE_W), .NUM_REN(NUM_REN)) alloc_u (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en_i  (alloc_en_i),
    .retire_i    (retire_i),
    .tail_done_i (tail_done),
    .grant_o     (grant),
    .tag_o       (tag),
    .stall_o     (stall_o),
    .retire_ok_o (retire_ok_o),
    .tail_o      (tail)
  );

  rnb_entries #(.ISSUE_W(ISSUE_W), .NUM_REN(NUM_REN), .NUM_ARCH(NUM_ARCH), .DW(DW)) ent_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_i    (grant),
    .dest_i     (dest_i),
    .tag_i      (tag),
    .wb_en_i    (wb_en_i),
    .wb_tag_i   (wb_tag_i),
    .wb_data_i  (wb_data_i),
    .free_en_i  (retire_ok_o),
    .free_tag_i (tail),
    .occ_o      (occ),
    .lat_o      (lat),
    .rdy_o      (rdy),
    .arch_o     (arch),
    .data_o     (data)
  );

  rnb_lookup #(.ISSUE_W(ISSUE_W), .NSRC(NSRC), .NUM_REN(NUM_REN), .NUM_ARCH(NUM_ARCH), .DW(DW)) look_u (
    .occ_i   (occ),
    .lat_i   (lat),
    .rdy_i   (rdy),
    .arch_i  (arch),
    .data_i  (data),
    .arf_i   (arf_q),
    .grant_i (grant),
    .dest_i  (dest_i),
    .tag_i   (tag),
    .src_i   (src_i),
    .rdy_o   (src_rdy_o),
    .val_o   (src_val_o),
    .tag_o   (src_tag_o)
  );

  // architectural register file, written only by retirement
  always_comb begin
    arf_we    = retire_ok_o;
    arf_idx   = arch[tail];
    arf_wdata = data[tail];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arf_q <= '0;
    end else if (arf_we) begin
      arf_q[arf_idx] <= arf_wdata;
    end
  end

  // R9: retirement only ever takes a live entry that holds its result
  a_r9_retire_ready: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok_o |-> (occ[tail] && rdy[tail] && retire_i));

  // R9: the retired value lands in the architectural file
  a_r9_arf_written: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ok_o |=> arf_q[$past(arf_idx)] == $past(arf_wdata));

endmodule

// File: tb/rnb_top_tb_top.sv
module rnb_top_tb_top;
  localparam int NA = 8, NR = 8, DW = 16, IW = 2, NS = 2, NL = IW * NS;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [IW-1:0]         alloc_en;
  logic [IW-1:0][2:0]    dest;
  logic [NL-1:0][2:0]    src;
  logic [IW-1:0][2:0]    atag;
  logic                  stall;
  logic [NL-1:0]         srdy;
  logic [NL-1:0][DW-1:0] sval;
  logic [NL-1:0][2:0]    stag;
  logic                  wb_en;
  logic [2:0]            wb_tag;
  logic [DW-1:0]         wb_data;
  logic                  retire;
  logic                  retire_ok;

  rnb_top #(.NUM_ARCH(NA), .NUM_REN(NR), .DW(DW), .ISSUE_W(IW), .NSRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_en_i(alloc_en), .dest_i(dest), .src_i(src),
    .alloc_tag_o(atag), .stall_o(stall), .src_rdy_o(srdy), .src_val_o(sval),
    .src_tag_o(stag), .wb_en_i(wb_en), .wb_tag_i(wb_tag), .wb_data_i(wb_data),
    .retire_i(retire), .retire_ok_o(retire_ok)
  );

  int nchk = 0, nbad = 0;
  bit done = 0;

  // map-table model of the buffer
  bit       m_occ[NR], m_rdy[NR];
  int       m_arch[NR];
  int       m_data[NR];
  int       m_arf[NA];
  bit       mv[NA];
  int       mmap[NA];
  int       m_head, m_tail, m_cnt;
  bit       e_gr[IW];
  int       e_gt[IW];
  bit       e_stall, e_rok;

  task automatic chk(input int act, input int exp, input string req, input string what);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_en = '0; dest = '0; src = '0;
    wb_en = 1'b0; wb_tag = '0; wb_data = '0; retire = 1'b0;
  endtask

  // compare every output against the model, before the edge
  task automatic check_cycle();
    int nreq, ng, grp, s, t;
    #1;
    nreq = 0;
    for (int k = 0; k < IW; k++) nreq += int'(alloc_en[k]);
    e_stall = (nreq > NR - m_cnt);
    chk(int'(stall), int'(e_stall), "R2", "stall");
    e_rok = retire && (m_cnt > 0) && m_rdy[m_tail];
    chk(int'(retire_ok), int'(e_rok), "R9", "retire_ok");
    ng = 0;
    for (int k = 0; k < IW; k++) begin
      e_gr[k] = !e_stall && alloc_en[k];
      e_gt[k] = (m_head + ng) % NR;
      if (e_gr[k]) begin
        chk(int'(atag[k]), e_gt[k], e_rok ? "R11" : "R1", "alloc_tag");
        ng++;
      end
    end
    for (int l = 0; l < NL; l++) begin
      s = l / NS;
      grp = -1;
      for (int k = 0; k < s; k++)
        if (e_gr[k] && int'(dest[k]) == int'(src[l])) grp = k;
      if (grp >= 0) begin
        chk(int'(srdy[l]), 0, "R7", "group rdy");
        chk(int'(stag[l]), e_gt[grp], "R7", "group tag");
      end else if (mv[src[l]]) begin
        t = mmap[src[l]];
        if (m_rdy[t]) begin
          chk(int'(srdy[l]), 1, "R5", "entry rdy");
          chk(int'(sval[l]), m_data[t], "R5", "entry val");
        end else begin
          chk(int'(srdy[l]), 0, "R4", "wait rdy");
          chk(int'(stag[l]), t, "R4", "wait tag");
        end
      end else begin
        chk(int'(srdy[l]), 1, "R6", "arch rdy");
        chk(int'(sval[l]), m_arf[src[l]], "R6", "arch val");
      end
    end
  endtask

  // apply the edge to the model, then move to the next drive point
  task automatic advance();
    int a, ng;
    if (e_rok) begin
      a = m_arch[m_tail];
      m_arf[a] = m_data[m_tail];
      if (mv[a] && mmap[a] == m_tail) mv[a] = 0;
      m_occ[m_tail] = 0;
      m_rdy[m_tail] = 0;
      m_tail = (m_tail + 1) % NR;
      m_cnt--;
    end
    if (wb_en && m_occ[wb_tag]) begin
      m_rdy[wb_tag] = 1;
      m_data[wb_tag] = int'(wb_data);
    end
    ng = 0;
    for (int k = 0; k < IW; k++) begin
      if (e_gr[k]) begin
        m_occ[e_gt[k]] = 1;
        m_rdy[e_gt[k]] = 0;
        m_arch[e_gt[k]] = int'(dest[k]);
        mv[dest[k]] = 1;
        mmap[dest[k]] = e_gt[k];
        ng++;
      end
    end
    m_head = (m_head + ng) % NR;
    m_cnt += ng;
    @(negedge clk);
  endtask

  task automatic rand_cycle(input int retire_pct);
    int pl[NR];
    int np, pick;
    alloc_en = IW'($urandom);
    for (int k = 0; k < IW; k++) dest[k] = 3'($urandom % NA);
    for (int l = 0; l < NL; l++) src[l] = 3'($urandom % NA);
    np = 0;
    for (int i = 0; i < NR; i++) if (m_occ[i] && !m_rdy[i]) begin pl[np] = i; np++; end
    wb_en = 1'b0;
    pick = int'($urandom % NR);
    if (($urandom % 6) == 0 && !m_occ[pick]) begin
      wb_en = 1'b1; wb_tag = 3'(pick);         // R8: write into a free entry, must be ignored
    end else if (np > 0 && ($urandom % 3) != 0) begin
      wb_en = 1'b1; wb_tag = 3'(pl[$urandom % np]);
    end
    wb_data = DW'($urandom);
    retire = (int'($urandom % 100) < retire_pct);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_occ[i] = 0; m_rdy[i] = 0; m_arch[i] = 0; m_data[i] = 0; end
    for (int a = 0; a < NA; a++) begin m_arf[a] = 0; mv[a] = 0; mmap[a] = 0; end
    m_head = 0; m_tail = 0; m_cnt = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: empty after reset
    for (int l = 0; l < NL; l++) src[l] = 3'(l);
    check_cycle();
    for (int l = 0; l < NL; l++) begin
      chk(int'(srdy[l]), 1, "R10", "reset rdy");
      chk(int'(sval[l]), 0, "R10", "reset val");
    end
    chk(int'(stall), 0, "R10", "reset stall");
    advance();

    // both slots rename register 5; slot 1 source sees slot 0
    idle_inputs();
    alloc_en = 2'b11; dest[0] = 3'd5; dest[1] = 3'd5;
    src[0] = 3'd5; src[2] = 3'd5; src[3] = 3'd3;
    check_cycle();
    chk(int'(srdy[2]), 0, "R7", "same-group rdy");
    chk(int'(stag[2]), 0, "R7", "same-group tag");
    chk(int'(srdy[0]), 1, "R7", "own dest hidden");
    advance();

    // youngest instance wins
    idle_inputs(); src[0] = 3'd5;
    check_cycle();
    chk(int'(stag[0]), 1, "R3", "latest tag");
    chk(int'(srdy[0]), 0, "R3", "latest rdy");
    advance();

    // writeback to free entry 6, retire with tail not ready
    idle_inputs(); wb_en = 1'b1; wb_tag = 3'd6; wb_data = 16'hdead; retire = 1'b1;
    check_cycle();
    chk(int'(retire_ok), 0, "R9", "tail not ready");
    advance();

    idle_inputs(); wb_en = 1'b1; wb_tag = 3'd0; wb_data = 16'h0111;
    check_cycle(); advance();

    // writeback and lookup of entry 1 in the same cycle; retire entry 0
    idle_inputs(); wb_en = 1'b1; wb_tag = 3'd1; wb_data = 16'h0222; retire = 1'b1; src[0] = 3'd5;
    check_cycle();
    chk(int'(srdy[0]), 0, "R8", "wb visible next cycle only");
    chk(int'(retire_ok), 1, "R9", "tail ready");
    advance();

    idle_inputs(); src[0] = 3'd5; retire = 1'b1;
    check_cycle();
    chk(int'(srdy[0]), 1, "R5", "entry value rdy");
    chk(int'(sval[0]), 16'h0222, "R5", "entry value");
    advance();

    idle_inputs(); src[0] = 3'd5;
    check_cycle();
    chk(int'(sval[0]), 16'h0222, "R9", "retired value in arch file");
    advance();

    // fill the ring (head = tail = 2)
    for (int c = 0; c < 4; c++) begin
      idle_inputs(); alloc_en = 2'b11; dest[0] = 3'(c); dest[1] = 3'(c + 4);
      check_cycle(); advance();
    end
    idle_inputs(); alloc_en = 2'b01; dest[0] = 3'd7;
    check_cycle();
    chk(int'(stall), 1, "R2", "full stall");
    advance();
    idle_inputs(); wb_en = 1'b1; wb_tag = 3'd2; wb_data = 16'h0333;
    check_cycle(); advance();
    idle_inputs(); alloc_en = 2'b01; dest[0] = 3'd7; retire = 1'b1;
    check_cycle();
    chk(int'(stall), 1, "R11", "full while retiring");
    chk(int'(retire_ok), 1, "R11", "retire while full");
    advance();
    idle_inputs(); alloc_en = 2'b01; dest[0] = 3'd7;
    check_cycle();
    chk(int'(stall), 0, "R11", "freed entry usable");
    chk(int'(atag[0]), 2, "R11", "freed index granted");
    advance();

    // sweeps at three retirement densities
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        rand_cycle(ph == 0 ? 15 : (ph == 1 ? 50 : 85));
        check_cycle();
        advance();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule